// File: doc/BRIEF.md
# Prefetching DMA Read Buffer Pair

This block serves block-mode DMA reads from a slow I/O bus whose word rate is at least four times lower than that of a host memory bus. It keeps two quadword buffers. The first read of a transfer misses, so the block requests the quadword that holds it from the host bus. The host grants ownership after a variable delay, and memory then returns the quadword as two longword beats. The block answers the I/O side as soon as the longword it needs has landed, without waiting for the second beat.

Once a buffer holds data for the word the I/O side is reading, the block fetches the next sequential quadword into the other buffer. It bets on the block transfer continuing, and stops at the end of the aligned eight-word block (`BLK_WORDS`). A read to a quadword that neither buffer holds or is filling throws away both buffers and starts a new demand fetch.

The I/O request side uses valid/ready. The requester keeps `io_req_valid` high and `io_req_addr` stable until it sees `io_req_ready`. `io_rdata` is valid in the cycle where both are high. The host request side also uses valid/ready. The block holds `hreq_valid` and `hreq_addr` until `hreq_ready`, which stands for the bus grant. Host return beats have no back-pressure: the block only requests when a buffer is free, so it always accepts a beat.

Top module: `qrp_rd_prefetch`

## Requirements
- R1: After reset, and with no I/O request, `hreq_valid` and `io_req_ready` stay low and no host request is issued.
- R2: A read whose quadword is not held issues a host request with `hreq_addr` equal to `io_req_addr[ADDR_W-1:3]`.
- R3: While `hreq_valid` is high and `hreq_ready` is low, the next cycle keeps `hreq_valid` high with the same `hreq_addr`.
- R4: `io_req_ready` rises in the cycle right after the host beat that carries the addressed longword. For a read of longword 0 this happens before beat 1 arrives.
- R5: Beat 0 carries bytes 0..3 of the quadword and beat 1 carries bytes 4..7. `io_req_addr[2]` picks the longword and `io_req_addr[1]` picks the half: 0 gives bits [WORD_W-1:0] and 1 gives the upper half. `io_req_addr[0]` is ignored. Data under repeated handshakes on the same address does not change.
- R6: After a demand fill or a hit in quadword Q, the block requests Q+1 with no I/O miss, provided Q+1 lies in the same block and is not already held.
- R7: No request is issued for a quadword beyond the end of the aligned block of `BLK_WORDS` words (`BLK_WORDS*2` bytes).
- R8: A read outside both held quadwords discards both buffers. A later read of a formerly held quadword fetches it again.
- R9: Reads that hit either buffer complete without any new host request being issued before the acknowledge.
- R10: At most one host fetch is in flight: `hreq_valid` stays low from a grant until both beats of that fetch have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req_valid | input | 1 | I/O word read request valid |
| io_req_ready | output | 1 | Acknowledge; `io_rdata` is valid |
| io_req_addr | input | ADDR_W | I/O byte address |
| io_rdata | output | WORD_W | Returned I/O word |
| hreq_valid | output | 1 | Host quadword read request |
| hreq_ready | input | 1 | Host bus grant / request accept |
| hreq_addr | output | ADDR_W-3 | Requested quadword address |
| hrsp_valid | input | 1 | Host return beat strobe |
| hrsp_data | input | 2*WORD_W | Returned longword |

## Verification
The bench builds the block with `BLK_WORDS=16`, so one block spans four quadwords. A sequential walk therefore prefetches three times and reuses each buffer before it reaches the block's end. The default `BLK_WORDS=8` allows only one prefetch per block, so buffer reuse would be out of reach. The host model in the bench varies the grant delay, the memory delay and the gap between beats. This places the early acknowledge between the two beats and keeps a request waiting for grant across many cycles.

// File: rtl/qrp_pkg.sv
package qrp_pkg;
  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_BEAT = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/qrp_buf.sv
// One quadword buffer: tag, per-longword fill flags and data.
module qrp_buf #(
  parameter int QA_W = 13,
  parameter int LW_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [QA_W-1:0] alloc_qa,
  input  logic            flush,
  input  logic            wr_en,
  input  logic            wr_idx,
  input  logic [LW_W-1:0] wr_data,
  input  logic [QA_W-1:0] rd_qa,
  input  logic            rd_idx,
  output logic            tag_hit,
  output logic            data_rdy,
  output logic [LW_W-1:0] rd_data,
  output logic [QA_W-1:0] tag,
  output logic            held
);
  logic            held_q;
  logic [QA_W-1:0] tag_q;
  logic [1:0]      ok_q;
  logic [1:0][LW_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      tag_q  <= '0;
      ok_q   <= 2'b00;
    end else if (alloc) begin
      held_q <= 1'b1;
      tag_q  <= alloc_qa;
      ok_q   <= 2'b00;
    end else if (flush) begin
      held_q <= 1'b0;
      ok_q   <= 2'b00;
    end else if (wr_en) begin
      ok_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q[wr_idx] <= wr_data;
  end

  assign tag_hit  = held_q && (tag_q == rd_qa);
  assign data_rdy = tag_hit && ok_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];
  assign tag      = tag_q;
  assign held     = held_q;
endmodule

// File: rtl/qrp_fetch.sv
// Host-side sequencer: request, wait for grant, collect two beats.
module qrp_fetch
  import qrp_pkg::*;
#(
  parameter int QA_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [QA_W-1:0] start_qa,
  input  logic            start_ent,
  input  logic            hreq_ready,
  input  logic            hrsp_valid,
  output logic            hreq_valid,
  output logic [QA_W-1:0] hreq_addr,
  output logic            idle,
  output logic [1:0]      beat_we,
  output logic            beat_idx
);
  fetch_st_e       st_q;
  logic [QA_W-1:0] qa_q;
  logic            ent_q;
  logic            idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= F_IDLE;
      qa_q  <= '0;
      ent_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      unique case (st_q)
        F_IDLE: if (start) begin
          st_q  <= F_REQ;
          qa_q  <= start_qa;
          ent_q <= start_ent;
        end
        F_REQ: if (hreq_ready) begin
          st_q  <= F_BEAT;
          idx_q <= 1'b0;
        end
        F_BEAT: if (hrsp_valid) begin
          idx_q <= 1'b1;
          if (idx_q) st_q <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign hreq_valid = (st_q == F_REQ);
  assign hreq_addr  = qa_q;
  assign idle       = (st_q == F_IDLE);
  assign beat_idx   = idx_q;

  always_comb begin
    beat_we = 2'b00;
    if (st_q == F_BEAT && hrsp_valid) beat_we[ent_q] = 1'b1;
  end
endmodule

// File: rtl/qrp_rd_prefetch.sv
// Two-quadword read buffer pair with sequential prefetch.
module qrp_rd_prefetch #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_req_valid,
  output logic                  io_req_ready,
  input  logic [ADDR_W-1:0]     io_req_addr,
  output logic [WORD_W-1:0]     io_rdata,
  output logic                  hreq_valid,
  input  logic                  hreq_ready,
  output logic [ADDR_W-4:0]     hreq_addr,
  input  logic                  hrsp_valid,
  input  logic [2*WORD_W-1:0]   hrsp_data
);
  localparam int QA_W = ADDR_W - 3;
  localparam int LW_W = 2 * WORD_W;
  localparam int QPB  = BLK_WORDS / 4;
  localparam int QB   = (QPB > 1) ? $clog2(QPB) : 1;

  logic [QA_W-1:0] io_qa;
  logic            io_lw, io_hi;
  logic            unused_addr_b0;

  logic [1:0]      tag_hit, data_rdy, held, alloc_e, beat_we;
  logic [QA_W-1:0] tag    [2];
  logic [LW_W-1:0] lw_out [2];
  logic            fetch_idle, beat_idx;
  logic            start, flush_all, miss, pf, in_blk, have_nxt;
  logic            start_ent, mru_q;
  logic [QA_W-1:0] mru_tag, nxt_qa, start_qa;
  logic [LW_W-1:0] sel_lw;

  assign io_qa          = io_req_addr[ADDR_W-1:3];
  assign io_lw          = io_req_addr[2];
  assign io_hi          = io_req_addr[1];
  assign unused_addr_b0 = io_req_addr[0];

  for (genvar g = 0; g < 2; g++) begin : g_buf
    assign alloc_e[g] = start && (start_ent == 1'(g));
    qrp_buf #(.QA_W(QA_W), .LW_W(LW_W)) u_buf (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc_e[g]),
      .alloc_qa (start_qa),
      .flush    (flush_all),
      .wr_en    (beat_we[g]),
      .wr_idx   (beat_idx),
      .wr_data  (hrsp_data),
      .rd_qa    (io_qa),
      .rd_idx   (io_lw),
      .tag_hit  (tag_hit[g]),
      .data_rdy (data_rdy[g]),
      .rd_data  (lw_out[g]),
      .tag      (tag[g]),
      .held     (held[g])
    );
  end

  qrp_fetch #(.QA_W(QA_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_qa   (start_qa),
    .start_ent  (start_ent),
    .hreq_ready (hreq_ready),
    .hrsp_valid (hrsp_valid),
    .hreq_valid (hreq_valid),
    .hreq_addr  (hreq_addr),
    .idle       (fetch_idle),
    .beat_we    (beat_we),
    .beat_idx   (beat_idx)
  );

  // Next sequential quadword and whether it stays inside the block.
  assign mru_tag = tag[mru_q];
  assign nxt_qa  = mru_tag + 1'b1;

  if (QPB > 1) begin : g_blk
    assign in_blk = (mru_tag[QB-1:0] != {QB{1'b1}});
  end else begin : g_noblk
    assign in_blk = 1'b0;
  end

  assign have_nxt = held[~mru_q] && (tag[~mru_q] == nxt_qa);

  // Demand miss has priority over prefetch; both wait for an idle host side.
  assign miss         = io_req_valid && (tag_hit == 2'b00);
  assign io_req_ready = io_req_valid && (data_rdy != 2'b00);
  assign pf           = !miss && held[mru_q] && in_blk && !have_nxt && !io_req_ready;
  assign start        = fetch_idle && (miss || pf);
  assign flush_all    = fetch_idle && miss;
  assign start_ent    = miss ? 1'b0 : ~mru_q;
  assign start_qa     = miss ? io_qa : nxt_qa;

  always_ff @(posedge clk) begin
    if (rst)               mru_q <= 1'b0;
    else if (flush_all)    mru_q <= 1'b0;
    else if (io_req_ready) mru_q <= data_rdy[1];
  end

  assign sel_lw   = data_rdy[1] ? lw_out[1] : lw_out[0];
  assign io_rdata = io_hi ? sel_lw[LW_W-1:WORD_W] : sel_lw[WORD_W-1:0];
endmodule

// File: rtl/qrp_chk.sv
// Protocol checker, bound to the top module.
module qrp_chk #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req_valid,
  input logic              io_req_ready,
  input logic [ADDR_W-1:0] io_req_addr,
  input logic [WORD_W-1:0] io_rdata,
  input logic              hreq_valid,
  input logic              hreq_ready,
  input logic [ADDR_W-4:0] hreq_addr,
  input logic              hrsp_valid
);
  logic [1:0] owed_q;

  always_ff @(posedge clk) begin
    if (rst)                                   owed_q <= 2'd0;
    else if (hreq_valid && hreq_ready)         owed_q <= 2'd2;
    else if (hrsp_valid && owed_q != 2'd0)     owed_q <= owed_q - 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hreq_valid && !io_req_ready));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (hreq_valid && !hreq_ready) |=> (hreq_valid && $stable(hreq_addr)));

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (io_req_valid && io_req_ready) |=>
      (!(io_req_valid && io_req_ready && $stable(io_req_addr)) || $stable(io_rdata)));

  assert_one_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    hreq_valid |-> (owed_q == 2'd0));
endmodule

bind qrp_rd_prefetch qrp_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_req_valid (io_req_valid),
  .io_req_ready (io_req_ready),
  .io_req_addr  (io_req_addr),
  .io_rdata     (io_rdata),
  .hreq_valid   (hreq_valid),
  .hreq_ready   (hreq_ready),
  .hreq_addr    (hreq_addr),
  .hrsp_valid   (hrsp_valid)
);

// File: tb/tb_qrp_rd_prefetch.sv
`timescale 1ns/1ps
module tb_qrp_rd_prefetch;
  localparam int AW = 16;
  localparam int WW = 16;
  localparam int BW = 16;
  localparam int QW = AW - 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          io_req_valid, io_req_ready;
  logic [AW-1:0] io_req_addr;
  logic [WW-1:0] io_rdata;
  logic          hreq_valid, hreq_ready;
  logic [QW-1:0] hreq_addr;
  logic          hrsp_valid;
  logic [2*WW-1:0] hrsp_data;

  qrp_rd_prefetch #(.ADDR_W(AW), .WORD_W(WW), .BLK_WORDS(BW)) dut (
    .clk(clk), .rst(rst),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_addr(io_req_addr), .io_rdata(io_rdata),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_addr(hreq_addr),
    .hrsp_valid(hrsp_valid), .hrsp_data(hrsp_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  function automatic logic [15:0] wfun(int w);
    return 16'(w * 7) ^ 16'hC3A5;
  endfunction
  function automatic logic [31:0] lwfun(int q, int k);
    int l = q * 2 + k;
    return {wfun(2 * l + 1), wfun(2 * l)};
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Host memory model
  int gdly = 1, mdly = 1, bgap = 0;
  int ph = 0, cnt = 0, nreq = 0, nbeat = 0, beat0_cyc = 0, hold_bad = 0, ovl_bad = 0;
  logic [QW-1:0] cur_q;
  logic [QW-1:0] rlog [64];

  always @(negedge clk) begin
    if (rst) begin
      ph = 0; cnt = 0; hreq_ready = 0; hrsp_valid = 0; hrsp_data = '0;
    end else begin
      if (ph >= 2 && hreq_valid) ovl_bad++;
      case (ph)
        0: begin
          hrsp_valid = 0;
          if (hreq_valid) begin
            if (cnt == 0) cur_q = hreq_addr;
            else if (hreq_addr != cur_q) hold_bad++;
            if (cnt >= gdly) begin hreq_ready = 1; ph = 1; end
            else cnt++;
          end
        end
        1: begin
          hreq_ready = 0;
          if (nreq < 64) rlog[nreq] = cur_q;
          nreq++; cnt = 0; ph = 2;
        end
        2: if (cnt >= mdly) begin
             hrsp_valid = 1; hrsp_data = lwfun(int'(cur_q), 0);
             nbeat++; beat0_cyc = cyc; cnt = 0; ph = 3;
           end else cnt++;
        3: begin
          hrsp_valid = 0;
          if (cnt >= bgap) begin
            hrsp_valid = 1; hrsp_data = lwfun(int'(cur_q), 1);
            nbeat++; ph = 4;
          end else cnt++;
        end
        default: begin hrsp_valid = 0; cnt = 0; ph = 0; end
      endcase
    end
  end

  task automatic io_read(input logic [AW-1:0] a, output logic [15:0] d, output int ack);
    int w = 0;
    @(negedge clk);
    io_req_addr = a; io_req_valid = 1; #1;
    while (!io_req_ready && w < 400) begin @(negedge clk); #1; w++; end
    if (!io_req_ready) chk(0, "R4 read timeout", int'(a), 0);
    d = io_rdata; ack = cyc;
    @(posedge clk); #1;
    io_req_valid = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; io_req_valid = 0; io_req_addr = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (6) @(negedge clk);
    chk(hreq_valid == 0, "R1 hreq_valid", int'(hreq_valid), 0);
    chk(io_req_ready == 0, "R1 io_req_ready", int'(io_req_ready), 0);
    chk(nreq == 0, "R1 request count", nreq, 0);
  endtask

  task automatic t_early_ack();
    logic [15:0] d; int ack, mark, b0;
    gdly = 3; mdly = 2; bgap = 6;
    mark = nreq; b0 = nbeat;
    io_read(16'h0100, d, ack);
    chk(rlog[mark] == 13'h20, "R2 demand addr", int'(rlog[mark]), 'h20);
    chk(ack == beat0_cyc + 1, "R4 ack cycle", ack, beat0_cyc + 1);
    chk(nbeat == b0 + 1, "R4 ack before beat1", nbeat - b0, 1);
    chk(d == wfun('h80), "R5 low half lw0", int'(d), int'(wfun('h80)));
    io_read(16'h0107, d, ack);
    chk(d == wfun('h83), "R5 high half lw1", int'(d), int'(wfun('h83)));
    io_read(16'h0104, d, ack);
    chk(d == wfun('h82), "R5 low half lw1", int'(d), int'(wfun('h82)));
    chk(nreq <= mark + 2, "R9 hits no demand", nreq - mark, 2);
    settle();
    chk(nreq == mark + 2, "R6 one prefetch", nreq - mark, 2);
    chk(rlog[mark + 1] == 13'h21, "R6 prefetch addr", int'(rlog[mark + 1]), 'h21);
  endtask

  task automatic t_walk();
    logic [15:0] d; int ack, mark, bad = 0;
    gdly = 1; mdly = 1; bgap = 0;
    mark = nreq;
    for (int w = 0; w < 16; w++) begin
      io_read(AW'(16'h0400 + 2 * w), d, ack);
      if (d != wfun('h200 + w)) begin
        bad++;
        chk(0, "R9 walk data", int'(d), int'(wfun('h200 + w)));
      end
    end
    chk(bad == 0, "R9 walk all words", bad, 0);
    settle();
    chk(nreq - mark == 4, "R7 walk request count", nreq - mark, 4);
    for (int k = 0; k < 4; k++)
      chk(rlog[mark + k] == QW'('h80 + k), "R6 walk order", int'(rlog[mark + k]), 'h80 + k);
  endtask

  task automatic t_block_end();
    logic [15:0] d; int ack, mark;
    gdly = 2; mdly = 1; bgap = 2;
    mark = nreq;
    io_read(16'h0618, d, ack);
    chk(d == wfun('h30C), "R5 block end data", int'(d), int'(wfun('h30C)));
    settle();
    chk(nreq - mark == 1, "R7 no prefetch past block", nreq - mark, 1);
    chk(rlog[mark] == 13'hC3, "R2 block end addr", int'(rlog[mark]), 'hC3);
  endtask

  task automatic t_discard();
    logic [15:0] d; int ack, mark;
    gdly = 2; mdly = 3; bgap = 1;
    io_read(16'h0240, d, ack);
    chk(d == wfun('h120), "R5 discard setup", int'(d), int'(wfun('h120)));
    settle();
    mark = nreq;
    io_read(16'h024E, d, ack);
    chk(nreq == mark, "R9 hit in second buffer", nreq - mark, 0);
    chk(d == wfun('h127), "R9 second buffer data", int'(d), int'(wfun('h127)));
    settle();
    mark = nreq;
    io_read(16'h0300, d, ack);
    chk(rlog[mark] == 13'h60, "R8 miss fetch", int'(rlog[mark]), 'h60);
    chk(d == wfun('h180), "R8 miss data", int'(d), int'(wfun('h180)));
    settle();
    mark = nreq;
    io_read(16'h0248, d, ack);
    chk(nreq > mark, "R8 refetch issued", nreq - mark, 1);
    chk(rlog[mark] == 13'h49, "R8 refetch addr", int'(rlog[mark]), 'h49);
    chk(d == wfun('h124), "R8 refetch data", int'(d), int'(wfun('h124)));
    settle();
  endtask

  task automatic t_grant_wait();
    logic [15:0] d; int ack, mark, t0;
    gdly = 12; mdly = 0; bgap = 0; hold_bad = 0;
    mark = nreq; t0 = cyc;
    io_read(16'h0800, d, ack);
    chk(hold_bad == 0, "R3 request held", hold_bad, 0);
    chk(ack - t0 >= 14, "R3 waits for grant", ack - t0, 14);
    chk(rlog[mark] == 13'h100, "R2 long grant addr", int'(rlog[mark]), 'h100);
    chk(d == wfun('h400), "R5 long grant data", int'(d), int'(wfun('h400)));
    settle();
    chk(ovl_bad == 0, "R10 single fetch", ovl_bad, 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_early_ack();
    t_walk();
    t_block_end();
    t_discard();
    t_grant_wait();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule